// File: doc/BRIEF.md
# Programmable Oversampling Averaging Decimator

This block turns a stream of raw 16-bit unsigned converter samples into one averaged 16-bit result per measurement stage. A stage begins with a start pulse. From then on, every sample that arrives with its valid strobe is added into a wide accumulator until a fixed number of samples has been collected. The accumulated sum is then divided by that number, rounded to nearest, saturated to 16 bits and presented with a single-cycle valid pulse.

A 2-bit rate field sets the nominal decimation rate N to 256, 128 or 64. Each stage averages 3·N samples, so a stage collects 768, 384 or 192 samples. With samples arriving every 4 µs, one result comes out every 3.072 ms, 1.536 ms or 0.768 ms. A higher rate gives less noise and a slower update.

The rate is captured when the stage starts. The division is exact: the sum is shifted right by log2(N), and the quotient is then multiplied by a fixed-point reciprocal of three.

Top module: `avg_decimator`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `res_valid` and `res_data` are all zero.
- R2: The rate code selects the number of samples per stage: 00 gives 768 (N=256), 01 gives 384 (N=128), and both 10 and 11 give 192 (N=64).
- R3: `res_data` equals floor((S + 3N/2) / 3N), where S is the sum of the accepted samples, limited to 65535. The all-full-scale input yields exactly 65535 without overflow.
- R4: The rate code is captured only on an accepted start. Any change to `rate_sel` during a stage leaves that stage's sample count and divisor unchanged.
- R5: The final sample is accumulated on some clock edge. `res_valid` is high for exactly one cycle, starting at the following edge, and `busy` falls on that same following edge.
- R6: A sample is counted only while `smp_valid` is high and the block is busy. Samples with `smp_valid` low, samples in the cycle of the start pulse, and samples in the cycle between the final sample and the result are ignored.
- R7: A `stage_start` pulse that arrives while `busy` is high is ignored.
- R8: `busy` rises on the clock edge that samples an accepted `stage_start`.
- R9: `res_data` holds its value until the next result is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Unsigned raw sample |
| rate_sel | input | 2 | Decimation rate code |
| stage_start | input | 1 | Start pulse for one stage |
| res_data | output | 16 | Averaged, rounded, saturated result |
| res_valid | output | 1 | One-cycle result strobe |
| busy | output | 1 | High while a stage is collecting samples |

## Verification
The hardest conditions to reach from the ports occur during a long stage: the rate code changes partway through, stray start pulses arrive while the block is busy, and samples arrive in the start cycle or in the one-cycle gap before the result. The bench injects all of these at random during stages with random gaps between samples. A stage that stopped at the wrong count then shows up as an early or late `res_valid`. The exact rounding boundary is a second condition that random data almost never hits. Directed stages therefore place a single sample of 96 or 95 in an otherwise zero 192-sample stage, which must round to 1 and 0 respectively. An all-full-scale 768-sample stage covers saturation.

// File: rtl/avgd_pkg.sv
package avgd_pkg;
  typedef enum logic [1:0] {
    RATE_256 = 2'b00,
    RATE_128 = 2'b01,
    RATE_64A = 2'b10,
    RATE_64B = 2'b11
  } rate_code_t;
endpackage

// File: rtl/avgd_rate_decode.sv
module avgd_rate_decode #(
  parameter int MAX_LOG2 = 8,
  parameter int CNT_W    = 10,
  parameter int SHIFT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         code_in,
  output logic [CNT_W-1:0]   limit,
  output logic [SHIFT_W-1:0] shift
);
  import avgd_pkg::*;

  rate_code_t code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load) code_d = rate_code_t'(code_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RATE_256;
    else        code_q <= code_d;
  end

  always_comb begin
    unique case (code_q)
      RATE_256: shift = SHIFT_W'(MAX_LOG2);
      RATE_128: shift = SHIFT_W'(MAX_LOG2 - 1);
      default:  shift = SHIFT_W'(MAX_LOG2 - 2);
    endcase
    limit = (CNT_W'(3) << shift) - CNT_W'(1);
  end

  AST_RATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shift)); // R4
endmodule

// File: rtl/avgd_counter.sv
module avgd_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == limit);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear && last) |=> (cnt_q == 0 || cnt_q > $past(cnt_q))); // R2
endmodule

// File: rtl/avgd_accum.sv
module avgd_accum #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  output logic [ACC_W-1:0]  acc
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clear)    acc_d = '0;
    else if (add) acc_d = acc_q + ACC_W'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clear) |=> (acc_q >= $past(acc_q))); // R3
endmodule

// File: rtl/avgd_scale.sv
module avgd_scale #(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 26,
  parameter int SHIFT_W = 4,
  parameter int RECIP_K = 24
) (
  input  logic [ACC_W-1:0]   acc,
  input  logic [SHIFT_W-1:0] shift,
  output logic [DATA_W-1:0]  avg
);
  localparam int SUM_W  = ACC_W + 1;
  localparam int PROD_W = SUM_W + RECIP_K;
  localparam logic [PROD_W-1:0] RECIP = PROD_W'(((64'd1 << RECIP_K) + 64'd2) / 64'd3);
  localparam logic [PROD_W-1:0] SAT   = PROD_W'((64'd1 << DATA_W) - 64'd1);

  logic [SUM_W-1:0]  half, rsum, quo;
  logic [PROD_W-1:0] prod, div3;

  always_comb begin
    half = SUM_W'(3) << (shift - SHIFT_W'(1));
    rsum = SUM_W'(acc) + half;
    quo  = rsum >> shift;
    prod = PROD_W'(quo) * RECIP;
    div3 = prod >> RECIP_K;
    if (div3 > SAT) avg = '1;
    else            avg = div3[DATA_W-1:0];
  end
endmodule

// File: rtl/avg_decimator.sv
module avg_decimator #(
  parameter int DATA_W   = 16,
  parameter int MAX_LOG2 = 8,
  parameter int RECIP_K  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [1:0]        rate_sel,
  input  logic              stage_start,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              busy
);
  localparam int CNT_W   = $clog2(3 << MAX_LOG2);
  localparam int ACC_W   = DATA_W + CNT_W;
  localparam int SHIFT_W = $clog2(MAX_LOG2 + 1);

  logic busy_q, busy_d, done_q, done_d, rv_q, rv_d;
  logic [DATA_W-1:0]  rd_q, rd_d, avg;
  logic [CNT_W-1:0]   limit;
  logic [SHIFT_W-1:0] shift;
  logic [ACC_W-1:0]   acc;
  logic stage_go, take, last;

  assign stage_go = stage_start && !busy_q;
  assign take     = smp_valid && busy_q && !done_q;

  avgd_rate_decode #(.MAX_LOG2(MAX_LOG2), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .load(stage_go), .code_in(rate_sel),
    .limit(limit), .shift(shift));

  avgd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(stage_go), .inc(take),
    .limit(limit), .last(last));

  avgd_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(stage_go), .add(take),
    .din(smp_data), .acc(acc));

  avgd_scale #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W), .RECIP_K(RECIP_K)) u_scl (
    .acc(acc), .shift(shift), .avg(avg));

  always_comb begin
    done_d = take && last;
    rv_d   = done_q;
    busy_d = busy_q;
    if (stage_go)    busy_d = 1'b1;
    else if (done_q) busy_d = 1'b0;
    rd_d = rd_q;
    if (done_q) rd_d = avg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      rv_q   <= rv_d;
      rd_q   <= rd_d;
    end
  end

  assign res_data  = rd_q;
  assign res_valid = rv_q;
  assign busy      = busy_q;

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> !busy_q); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stage_start && !done_q) |=> busy_q); // R7
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    stage_go |=> busy_q); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |=> $stable(rd_q)); // R9
  AST_IDLE_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !rv_q); // R6
endmodule

// File: tb/avg_decimator_bench.sv
module avg_decimator_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid, stage_start;
  logic [15:0] smp_data;
  logic [1:0]  rate_sel;
  logic [15:0] res_data;
  logic res_valid, busy;

  int total = 0;
  int bad   = 0;
  int special_v = 0;
  logic [15:0] last_res;

  always #2.5 clk = ~clk;

  avg_decimator u_avg_decimator (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rate_sel(rate_sel), .stage_start(stage_start),
    .res_data(res_data), .res_valid(res_valid), .busy(busy));

  function automatic int samples_for(int code);
    int n;
    n = (code == 0) ? 256 : (code == 1) ? 128 : 64;
    return 3 * n;
  endfunction

  function automatic longint exp_avg(longint sum, int code);
    longint d, r;
    d = samples_for(code);
    r = (sum + d / 2) / d;
    if (r > 65535) r = 65535;
    return r;
  endfunction

  function automatic logic [15:0] pat_val(int pat, int i);
    case (pat)
      1: return 16'hFFFF;
      2: return 16'h0000;
      3: return 16'(32700 - 64 + ($urandom % 128));
      4: return (i == 0) ? 16'(special_v) : 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_stage(input int code, input int pat, input bit noise);
    longint sum = 0;
    int n = samples_for(code);
    int early = 0;
    @(negedge clk);
    rate_sel    = 2'(code);
    stage_start = 1'b1;
    smp_valid   = noise;            // R6: sample in the start cycle is ignored
    smp_data    = 16'($urandom);
    @(negedge clk);
    stage_start = 1'b0;
    smp_valid   = 1'b0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    for (int i = 0; i < n; i++) begin
      if (noise) begin
        for (int g = 0; g < int'($urandom % 3); g++) begin
          smp_valid   = 1'b0;
          smp_data    = 16'($urandom);
          rate_sel    = 2'($urandom);       // R4
          stage_start = ($urandom % 4) == 0; // R7
          @(negedge clk);
          if (res_valid) early++;
        end
      end
      stage_start = 1'b0;
      smp_valid   = 1'b1;
      smp_data    = pat_val(pat, i);
      sum        += smp_data;
      @(negedge clk);
      if (res_valid) early++;
    end
    // Cycle between final sample and result: inputs must be ignored (R6, R7)
    smp_valid   = noise;
    smp_data    = 16'hFFFF;
    stage_start = noise;
    check(early == 0 && busy == 1'b1, "R2/R4 no early result", early, 0);
    @(negedge clk);
    smp_valid   = 1'b0;
    stage_start = 1'b0;
    check(res_valid == 1'b1, "R5 result strobe", res_valid, 1);
    check(busy == 1'b0, "R5 busy drop", busy, 0);
    check(longint'(res_data) == exp_avg(sum, code), "R3 average value", res_data, exp_avg(sum, code));
    last_res = res_data;
    @(negedge clk);
    check(res_valid == 1'b0, "R5 single pulse", res_valid, 0);
    smp_valid = 1'b1;               // R6: idle samples ignored
    smp_data  = 16'($urandom);
    repeat (3) @(negedge clk);
    smp_valid = 1'b0;
    check(res_data == last_res && busy == 1'b0 && res_valid == 1'b0,
          "R9/R6 result held while idle", res_data, last_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; smp_valid = 1'b0; stage_start = 1'b0;
    smp_data = '0; rate_sel = '0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy in reset", busy, 0);
    check(res_valid == 0, "R1 res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_data == 0 && busy == 0, "R1 state after reset", res_data, 0);

    run_stage(0, 1, 1'b0);   // R3 saturation boundary: 768 full-scale
    run_stage(1, 3, 1'b1);   // R2 code 01, near midscale, noisy
    run_stage(2, 0, 1'b1);   // R2 code 10
    run_stage(3, 0, 1'b1);   // R2 code 11 same as 10
    special_v = 96;
    run_stage(2, 4, 1'b0);   // R3 exact half rounds up -> 1
    check(res_data == 16'd1, "R3 half rounds up", res_data, 1);
    special_v = 95;
    run_stage(3, 4, 1'b0);   // R3 below half -> 0
    check(res_data == 16'd0, "R3 below half", res_data, 0);
    run_stage(0, 2, 1'b1);   // all zero with noise
    run_stage(3, 1, 1'b1);   // saturation on short stage
    for (int k = 0; k < 4; k++) run_stage(int'($urandom % 4), int'($urandom % 4), 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule